// File: doc/BRIEF.md
# Compact instruction executor

This block runs the short (two-byte) instruction subset of a small 32-bit processor against a sixteen-entry register file and a program counter. Each cycle an instruction may be offered on a valid strobe as its first two bytes. The block decides the instruction length from the major opcode and updates the program counter. It performs register arithmetic, immediate loads, register moves, a return through register 0 and zero-compare branches. Word loads and stores go out through a request/response memory port.

Each instruction offer is two bytes. Byte 0 carries the major opcode in bits [3:0] and field `t` in bits [7:4]. Byte 1 carries field `s` in bits [3:0] and field `r` in bits [7:4]. The third byte of a long instruction is never needed, because long instructions are only stepped over. A load holds the block busy (`exec_ready` low) until the memory answers. All other instructions complete in the cycle they are accepted.

Top module: `dense_exec`

## Requirements
- R1: A major opcode (byte 0 bits [3:0]) below 8 is a three-byte instruction: the PC advances by 3 and no register changes. A major opcode of 8 or above is two bytes long.
- R2: Opcode 10 writes register r with register s plus register t, modulo 2^32, and the PC advances by 2.
- R3: Opcode 11 writes register r with register s plus the t field taken as an unsigned immediate. A t field of 0 adds -1 instead. The PC advances by 2.
- R4: Opcode 12 with t below 8 writes register s with the 7-bit value {t[2:0], r}. The upper 25 bits are filled with ones when t[2:1] is 2'b11 and with zeros otherwise. The PC advances by 2.
- R5: Opcode 12 with t of 8 or more is a branch on register s. t[2]=0 takes the branch when s equals zero, and t[2]=1 takes it when s is nonzero. A taken branch moves the PC to PC + 4 + {t[1:0], r} (unsigned, 0..63). An untaken branch moves it to PC + 2.
- R6: Opcode 8 issues a one-cycle read request at address register s + 4*r and holds the PC. When the response arrives it writes the returned word to register t and advances the PC by 2.
- R7: Opcode 9 issues a one-cycle write request at address register s + 4*r with the data of register t, and advances the PC by 2 at once.
- R8: Opcode 13 with r = 0 copies register s into register t, and the PC advances by 2.
- R9: Opcode 13 with r = 15 and t = 0 loads the PC with the value of register 0.
- R10: Opcode 13 with r = 15 and t = 3, any other opcode-13 pattern, and opcodes 14 and 15 advance the PC by 2 and change no register.
- R11: Synchronous reset sets the PC and every register to zero, drops any pending load and leaves the block ready.
- R12: While a load waits for its response, `exec_ready` is low. Offered instructions are ignored and the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | An instruction is offered this cycle |
| exec_byte0 | input | 8 | Instruction byte 0: opcode [3:0], field t [7:4] |
| exec_byte1 | input | 8 | Instruction byte 1: field s [3:0], field r [7:4] |
| exec_ready | output | 1 | High when an offered instruction is accepted |
| pc_o | output | 32 | Current program counter |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_we | output | 1 | 1 for a write request, 0 for a read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response is valid this cycle |
| mem_rsp_data | input | 32 | Read response word |

## Verification
The bound checker watches every cycle for the control-flow and handshake properties. It checks the three-byte step, the shape of load and store requests, the held PC and low ready while a load waits, the two-byte advance when the response arrives, and the state right after reset. Register contents, immediate encodings, branch targets and the effect of ignored or reserved encodings can only be shown by the bench. The bench drives these scenarios and then reads each affected register back through a store request.

// File: rtl/dense_pkg.sv
package dense_pkg;
  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_ADDI,
    OP_MOVI,
    OP_BRZ,
    OP_LOAD,
    OP_STORE,
    OP_MOV,
    OP_RET
  } op_kind_e;

  localparam int unsigned FLD_W = 4;

  localparam logic [3:0] MAJ_LOAD  = 4'd8;
  localparam logic [3:0] MAJ_STORE = 4'd9;
  localparam logic [3:0] MAJ_ADD   = 4'd10;
  localparam logic [3:0] MAJ_ADDI  = 4'd11;
  localparam logic [3:0] MAJ_IMM   = 4'd12;
  localparam logic [3:0] MAJ_MISC  = 4'd13;

  localparam logic [3:0] MISC_MOV_R = 4'd0;
  localparam logic [3:0] MISC_SYS_R = 4'd15;
  localparam logic [3:0] SYS_RET_T  = 4'd0;
endpackage

// File: rtl/dense_decode.sv
module dense_decode
  import dense_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [7:0]       byte0,
  input  logic [7:0]       byte1,
  output op_kind_e         kind,
  output logic             wide,
  output logic [FLD_W-1:0] fs,
  output logic [FLD_W-1:0] ft,
  output logic [FLD_W-1:0] fr,
  output logic [XLEN-1:0]  imm,
  output logic             br_ne,
  output logic [5:0]       br_off
);
  logic [3:0] major;

  always_comb begin
    major  = byte0[3:0];
    ft     = byte0[7:4];
    fs     = byte1[3:0];
    fr     = byte1[7:4];
    wide   = ~major[3];
    br_ne  = ft[2];
    br_off = {ft[1:0], fr};
    kind   = OP_NONE;
    imm    = '0;
    unique case (major)
      MAJ_LOAD: begin
        kind = OP_LOAD;
        imm  = XLEN'({fr, 2'b00});
      end
      MAJ_STORE: begin
        kind = OP_STORE;
        imm  = XLEN'({fr, 2'b00});
      end
      MAJ_ADD:  kind = OP_ADD;
      MAJ_ADDI: begin
        kind = OP_ADDI;
        imm  = (ft == '0) ? '1 : XLEN'(ft);
      end
      MAJ_IMM: begin
        if (ft[3]) begin
          kind = OP_BRZ;
        end else begin
          kind = OP_MOVI;
          imm  = {{(XLEN-7){ft[2] & ft[1]}}, ft[2:0], fr};
        end
      end
      MAJ_MISC: begin
        if (fr == MISC_MOV_R)
          kind = OP_MOV;
        else if (fr == MISC_SYS_R && ft == SYS_RET_T)
          kind = OP_RET;
        else
          kind = OP_NONE;
      end
      default: kind = OP_NONE;
    endcase
  end
endmodule

// File: rtl/dense_regfile.sv
module dense_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_b,
  output logic [XLEN-1:0] rdata_zero
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NREG); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a    = mem[raddr_a];
  assign rdata_b    = mem[raddr_b];
  assign rdata_zero = mem[0];
endmodule

// File: rtl/dense_next_pc.sv
module dense_next_pc
  import dense_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  op_kind_e        kind,
  input  logic            wide,
  input  logic [XLEN-1:0] s_val,
  input  logic [XLEN-1:0] zero_val,
  input  logic            br_ne,
  input  logic [5:0]      br_off,
  output logic [XLEN-1:0] nxt
);
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] tgt_pc;
  logic            taken;

  always_comb begin
    seq_pc = pc + (wide ? XLEN'(3) : XLEN'(2));
    tgt_pc = pc + XLEN'(4) + XLEN'(br_off);
    taken  = (s_val == '0) != br_ne;
    unique case (kind)
      OP_RET:  nxt = zero_val;
      OP_BRZ:  nxt = taken ? tgt_pc : seq_pc;
      default: nxt = seq_pc;
    endcase
  end
endmodule

// File: rtl/dense_exec.sv
module dense_exec
  import dense_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exec_valid,
  input  logic [7:0]      exec_byte0,
  input  logic [7:0]      exec_byte1,
  output logic            exec_ready,
  output logic [XLEN-1:0] pc_o,
  output logic            mem_req_valid,
  output logic            mem_req_we,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data
);
  localparam int unsigned AW = $clog2(NREG);

  op_kind_e        kind;
  logic            wide;
  logic [FLD_W-1:0] fs, ft, fr;
  logic [XLEN-1:0] imm;
  logic            br_ne;
  logic [5:0]      br_off;

  logic [XLEN-1:0] s_val, t_val, zero_val, nxt_pc;
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  logic [XLEN-1:0] pc_q;
  logic            wait_q;
  logic [AW-1:0]   ld_dst_q;
  logic            req_v_q, req_we_q;
  logic [XLEN-1:0] req_addr_q, req_wd_q;
  logic            accept;

  dense_decode #(.XLEN(XLEN)) u_dec (
    .byte0 (exec_byte0),
    .byte1 (exec_byte1),
    .kind  (kind),
    .wide  (wide),
    .fs    (fs),
    .ft    (ft),
    .fr    (fr),
    .imm   (imm),
    .br_ne (br_ne),
    .br_off(br_off)
  );

  dense_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (rf_we),
    .waddr     (rf_waddr),
    .wdata     (rf_wdata),
    .raddr_a   (fs[AW-1:0]),
    .rdata_a   (s_val),
    .raddr_b   (ft[AW-1:0]),
    .rdata_b   (t_val),
    .rdata_zero(zero_val)
  );

  dense_next_pc #(.XLEN(XLEN)) u_npc (
    .pc      (pc_q),
    .kind    (kind),
    .wide    (wide),
    .s_val   (s_val),
    .zero_val(zero_val),
    .br_ne   (br_ne),
    .br_off  (br_off),
    .nxt     (nxt_pc)
  );

  assign accept = exec_valid & ~wait_q;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = fr[AW-1:0];
    rf_wdata = '0;
    if (wait_q) begin
      rf_we    = mem_rsp_valid;
      rf_waddr = ld_dst_q;
      rf_wdata = mem_rsp_data;
    end else if (exec_valid) begin
      unique case (kind)
        OP_ADD: begin
          rf_we    = 1'b1;
          rf_waddr = fr[AW-1:0];
          rf_wdata = s_val + t_val;
        end
        OP_ADDI: begin
          rf_we    = 1'b1;
          rf_waddr = fr[AW-1:0];
          rf_wdata = s_val + imm;
        end
        OP_MOVI: begin
          rf_we    = 1'b1;
          rf_waddr = fs[AW-1:0];
          rf_wdata = imm;
        end
        OP_MOV: begin
          rf_we    = 1'b1;
          rf_waddr = ft[AW-1:0];
          rf_wdata = s_val;
        end
        default: rf_we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      wait_q     <= 1'b0;
      ld_dst_q   <= '0;
      req_v_q    <= 1'b0;
      req_we_q   <= 1'b0;
      req_addr_q <= '0;
      req_wd_q   <= '0;
    end else begin
      req_v_q <= 1'b0;
      if (wait_q) begin
        if (mem_rsp_valid) begin
          wait_q <= 1'b0;
          pc_q   <= pc_q + XLEN'(2);
        end
      end else if (accept) begin
        unique case (kind)
          OP_LOAD: begin
            req_v_q    <= 1'b1;
            req_we_q   <= 1'b0;
            req_addr_q <= s_val + imm;
            wait_q     <= 1'b1;
            ld_dst_q   <= ft[AW-1:0];
          end
          OP_STORE: begin
            req_v_q    <= 1'b1;
            req_we_q   <= 1'b1;
            req_addr_q <= s_val + imm;
            req_wd_q   <= t_val;
            pc_q       <= nxt_pc;
          end
          default: pc_q <= nxt_pc;
        endcase
      end
    end
  end

  assign exec_ready    = ~wait_q;
  assign pc_o          = pc_q;
  assign mem_req_valid = req_v_q;
  assign mem_req_we    = req_we_q;
  assign mem_req_addr  = req_addr_q;
  assign mem_req_wdata = req_wd_q;
endmodule

// File: rtl/dense_exec_chk.sv
module dense_exec_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            exec_valid,
  input logic [7:0]      exec_byte0,
  input logic            exec_ready,
  input logic [XLEN-1:0] pc_o,
  input logic            mem_req_valid,
  input logic            mem_req_we,
  input logic            mem_rsp_valid
);
  // R1: a long instruction steps the PC by three
  a_r1_wide_step: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && exec_ready && !exec_byte0[3]) |=> (pc_o == $past(pc_o) + XLEN'(3)));

  // R6: an accepted load raises a read request and goes busy
  a_r6_load_request: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && exec_ready && exec_byte0[3:0] == 4'd8) |=>
      (mem_req_valid && !mem_req_we && !exec_ready));

  // R6: the response releases the stall and steps the PC by two
  a_r6_load_release: assert property (@(posedge clk) disable iff (rst)
    (!exec_ready && mem_rsp_valid) |=> (exec_ready && pc_o == $past(pc_o) + XLEN'(2)));

  // R7: an accepted store raises a write request without stalling
  a_r7_store_request: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && exec_ready && exec_byte0[3:0] == 4'd9) |=>
      (mem_req_valid && mem_req_we && exec_ready && pc_o == $past(pc_o) + XLEN'(2)));

  // R12: a pending load holds the PC and keeps ready low
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (!exec_ready && !mem_rsp_valid) |=> ($stable(pc_o) && !exec_ready));

  // R11: the first cycle out of reset shows a cleared, idle block
  a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_o == '0 && exec_ready && !mem_req_valid));
endmodule

bind dense_exec dense_exec_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .exec_valid   (exec_valid),
  .exec_byte0   (exec_byte0),
  .exec_ready   (exec_ready),
  .pc_o         (pc_o),
  .mem_req_valid(mem_req_valid),
  .mem_req_we   (mem_req_we),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/sim_dense_exec.sv
`timescale 1ns/1ps
module sim_dense_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_valid = 1'b0;
  logic [7:0]  exec_byte0 = '0;
  logic [7:0]  exec_byte1 = '0;
  logic        exec_ready;
  logic [31:0] pc_o;
  logic        mem_req_valid, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dense_exec u0 (
    .clk(clk), .rst(rst),
    .exec_valid(exec_valid), .exec_byte0(exec_byte0), .exec_byte1(exec_byte1),
    .exec_ready(exec_ready), .pc_o(pc_o),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // byte0 = {t, op}, byte1 = {r, s}
  function automatic logic [15:0] enc(input logic [3:0] op, t, s, r);
    return {r, s, t, op};
  endfunction

  // {insn 16, check reg 4, expected value 32, pc delta 32, requirement 8}
  localparam int NV = 22;
  localparam logic [91:0] TBL [NV] = '{
    {enc(12, 5, 1, 3),    4'd1,  32'h0000_0053, 32'd2,  8'd4},  // R4 zero-extended
    {enc(12, 6, 2, 4'hA), 4'd2,  32'hFFFF_FFEA, 32'd2,  8'd4},  // R4 ones fill
    {enc(12, 7, 3, 4'hF), 4'd3,  32'hFFFF_FFFF, 32'd2,  8'd4},  // R4 ones fill
    {enc(12, 2, 11, 5),   4'd11, 32'h0000_0025, 32'd2,  8'd4},  // R4 t&6 != 6
    {enc(10, 2, 1, 4),    4'd4,  32'h0000_003D, 32'd2,  8'd2},  // R2
    {enc(11, 0, 1, 5),    4'd5,  32'h0000_0052, 32'd2,  8'd3},  // R3 zero means -1
    {enc(11, 15, 1, 6),   4'd6,  32'h0000_0062, 32'd2,  8'd3},  // R3
    {enc(10, 3, 3, 12),   4'd12, 32'hFFFF_FFFE, 32'd2,  8'd2},  // R2 wrap
    {enc(13, 7, 4, 0),    4'd7,  32'h0000_003D, 32'd2,  8'd8},  // R8
    {enc(3, 7, 7, 7),     4'd7,  32'h0000_003D, 32'd3,  8'd1},  // R1
    {enc(0, 4, 4, 4),     4'd4,  32'h0000_003D, 32'd3,  8'd1},  // R1
    {enc(13, 3, 1, 15),   4'd1,  32'h0000_0053, 32'd2,  8'd10}, // R10 no-op
    {enc(14, 1, 2, 3),    4'd1,  32'h0000_0053, 32'd2,  8'd10}, // R10
    {enc(15, 2, 2, 2),    4'd2,  32'hFFFF_FFEA, 32'd2,  8'd10}, // R10
    {enc(13, 1, 2, 5),    4'd1,  32'h0000_0053, 32'd2,  8'd10}, // R10
    {enc(13, 1, 0, 15),   4'd0,  32'h0000_0000, 32'd2,  8'd10}, // R10
    {enc(12, 8, 0, 5),    4'd0,  32'h0000_0000, 32'd9,  8'd5},  // R5 eq taken
    {enc(12, 12, 0, 3),   4'd0,  32'h0000_0000, 32'd2,  8'd5},  // R5 ne not taken
    {enc(12, 15, 1, 15),  4'd1,  32'h0000_0053, 32'd67, 8'd5},  // R5 ne taken, max offset
    {enc(12, 11, 1, 1),   4'd1,  32'h0000_0053, 32'd2,  8'd5},  // R5 eq not taken
    {enc(12, 11, 13, 15), 4'd13, 32'h0000_0000, 32'd67, 8'd5},  // R5 eq taken
    {enc(12, 13, 2, 0),   4'd2,  32'hFFFF_FFEA, 32'd20, 8'd5}   // R5 ne taken
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    exec_valid = 1'b1;
    exec_byte0 = w[7:0];
    exec_byte1 = w[15:8];
    @(negedge clk);
    exec_valid = 1'b0;
  endtask

  task automatic peek(input logic [3:0] rg, output logic [31:0] val);
    issue(enc(9, rg, 0, 0));
    chk("R7 observe", {30'd0, mem_req_valid, mem_req_we}, 32'd3);
    val = mem_req_wdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] pc0, val;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 pc", pc_o, 32'd0);
    chk("R11 ready", {31'd0, exec_ready}, 32'd1);
    chk("R11 req", {31'd0, mem_req_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      pc0 = pc_o;
      issue(TBL[i][91:76]);
      chk($sformatf("R%0d pc", TBL[i][7:0]), pc_o, pc0 + TBL[i][39:8]);
      peek(TBL[i][75:72], val);
      chk($sformatf("R%0d reg", TBL[i][7:0]), val, TBL[i][71:40]);
    end

    // R6 / R12: load with stall and ignored instructions
    issue(enc(12, 2, 8, 0));           // reg8 = 0x20
    pc0 = pc_o;
    issue(enc(8, 9, 8, 3));            // load reg9 from 0x2C
    chk("R6 req", {30'd0, mem_req_valid, mem_req_we}, 32'd2);
    chk("R6 addr", mem_req_addr, 32'h0000_002C);
    chk("R12 ready", {31'd0, exec_ready}, 32'd0);
    chk("R6 pc held", pc_o, pc0);
    exec_valid = 1'b1;
    exec_byte0 = enc(12, 1, 10, 1)[7:0];
    exec_byte1 = enc(12, 1, 10, 1)[15:8];
    repeat (3) @(negedge clk);
    chk("R12 pc stable", pc_o, pc0);
    chk("R12 still busy", {31'd0, exec_ready}, 32'd0);
    exec_valid = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_data = 32'hCAFE_F00D;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R6 pc after", pc_o, pc0 + 32'd2);
    chk("R6 ready", {31'd0, exec_ready}, 32'd1);
    peek(4'd9, val);
    chk("R6 data", val, 32'hCAFE_F00D);
    peek(4'd10, val);
    chk("R12 ignored", val, 32'd0);

    // R7: store address and data
    pc0 = pc_o;
    issue(enc(9, 1, 8, 2));
    chk("R7 addr", mem_req_addr, 32'h0000_0028);
    chk("R7 data", mem_req_wdata, 32'h0000_0053);
    chk("R7 pc", pc_o, pc0 + 32'd2);

    // R9: return through register 0
    issue(enc(12, 4, 0, 0));           // reg0 = 0x40
    issue(enc(13, 0, 0, 15));
    chk("R9 pc", pc_o, 32'h0000_0040);

    // R11: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R11 pc again", pc_o, 32'd0);
    peek(4'd1, val);
    chk("R11 regs cleared", val, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule